// File: doc/BRIEF.md
# Tiled Framebuffer Offset Generator

This block turns a pixel coordinate in a 32-bit-per-pixel image into the byte offset of that pixel in a framebuffer that uses a three-level tiled layout. At the bottom level, 4x4 pixels form a 64-byte micro-tile with pixels in raster order. Sixteen micro-tiles in a 4x4 raster grid form a 1 KB sub-tile that covers 16x16 pixels. Four sub-tiles in a 2x2 grid form a 4 KB tile that covers 32x32 pixels. Tile rows follow a serpentine order: even rows run left to right and odd rows run right to left. The order of the four sub-tiles inside a tile also changes between even and odd tile rows.

A request carries a coordinate, the image width in whole tiles (the pixel width plus 31, shifted right by five) and a base address that is added to the result. Requests arrive on a valid/ready handshake. Each accepted request produces one registered result one cycle later on a matching output handshake with backpressure. A display or fetch engine can stream coordinates through the block and get one offset per cycle.

Top module: `tt_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears `outValid` in the cycle after the reset edge, even while a result is stalled.
- R2: `inReady` is high exactly when the output register is empty or `outReady` is high, so a new request can be taken in the same cycle that the held result drains.
- R3: A request accepted on a clock edge makes `outValid` high after that edge. While `outValid` is high and `outReady` is low, `outOffset` and `outValid` stay unchanged.
- R4: Bits 1:0 of x and y select the pixel inside a micro-tile and add (yPix*4 + xPix)*4 bytes.
- R5: Bits 3:2 of x and y select the micro-tile inside a sub-tile and add (yMicro*4 + xMicro)*64 bytes.
- R6: Bit 4 of x is the sub-tile column and bit 4 of y is the sub-tile row, where 0 means bottom. In even tile rows (bit 5 of y is 0) the slot is bottom-left 0, top-left 1, top-right 2, bottom-right 3. The slot adds slot*1024 bytes.
- R7: In odd tile rows the slot is top-right 0, bottom-right 1, bottom-left 2, top-left 3.
- R8: In an even tile row the tile index is row*tilesPerRow + column, with column = x>>5 and row = y>>5. The index adds index*4096 bytes.
- R9: In an odd tile row the column term is replaced by tilesPerRow-1-column. With tilesPerRow of 1 this is column 0.
- R10: `baseAddr` is added to the computed offset, modulo 2^OFF_W.
- R11: The 1024 pixels of any one tile map to 1024 distinct word-aligned offsets that all lie in that tile's own 4 KB span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Request can be accepted |
| inX | input | COORD_W | Pixel column |
| inY | input | COORD_W | Pixel row |
| tilesPerRow | input | TPR_W | Image width in whole tiles |
| baseAddr | input | OFF_W | Byte address added to every result |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Consumer takes the result |
| outOffset | output | OFF_W | Byte offset of the pixel |

## Verification
The bench uses the default parameters: 12-bit coordinates, an 8-bit tiles-per-row field and 32-bit offsets. With 12-bit coordinates the image reaches 128 tile rows, so even and odd rows up to the far corner (4095, 4095) are reachable. With 128 tiles per row the tile index grows past the 4 KB field, which exercises the upper offset bits and the base addition. A width of one tile is reachable and is the degenerate mirror case. A width of five tiles, which is odd, shows whether the mirrored column is counted from the true row end rather than from a power-of-two boundary.

// File: rtl/tt_pkg.sv
package tt_pkg;

  // Byte-offset field positions of the tiled layout (32 bpp)
  localparam int PIX_LSB   = 2;   // 4 bytes per pixel
  localparam int MICRO_LSB = 6;   // 64-byte micro-tile
  localparam int SLOT_LSB  = 10;  // 1 KB sub-tile
  localparam int TILE_LSB  = 12;  // 4 KB tile
  localparam int TILE_SHIFT = 5;  // 32 pixels per tile side

  // Sub-tile position inside a tile, written {row, col}, row 0 = bottom
  typedef enum logic [1:0] {
    POS_BL = 2'b00,
    POS_BR = 2'b01,
    POS_TL = 2'b10,
    POS_TR = 2'b11
  } tt_pos_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new result
    logic drain;  // held result leaves without replacement
  } tt_strobe_t;

endpackage

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output tt_strobe_t strobe
);

  logic validQ;

  assign inReady      = !validQ || outReady;
  assign strobe.load  = inValid && inReady;
  assign strobe.drain = validQ && outReady && !strobe.load;
  assign outValid     = validQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
    end else if (strobe.load) begin
      validQ <= 1'b1;
    end else if (strobe.drain) begin
      validQ <= 1'b0;
    end
  end

  // R1: reset empties the output stage
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !outValid);

  // R2: a stalled result blocks any new capture
  a_r2_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (validQ && !outReady) |-> !strobe.load);

  // R3: an accepted request is presented on the next cycle
  a_r3_accept_valid: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> outValid);

endmodule

// File: rtl/tt_slot_map.sv
module tt_slot_map
  import tt_pkg::*;
(
  input  logic       oddRow,
  input  logic       subCol,
  input  logic       subRow,
  output logic [1:0] slot
);

  tt_pos_e    pos;
  logic [1:0] evenSlot;

  assign pos = tt_pos_e'({subRow, subCol});

  // Even tile rows: BL, TL, TR, BR
  always_comb begin
    unique case (pos)
      POS_BL:  evenSlot = 2'd0;
      POS_TL:  evenSlot = 2'd1;
      POS_TR:  evenSlot = 2'd2;
      default: evenSlot = 2'd3;  // POS_BR
    endcase
  end

  // Odd rows (TR, BR, BL, TL) are the even order rotated by two slots
  assign slot = evenSlot + {oddRow, 1'b0};

endmodule

// File: rtl/tt_tile_index.sv
module tt_tile_index #(
  parameter int TC_W  = 7,
  parameter int TPR_W = 8,
  parameter int IDX_W = TC_W + TPR_W + 1
) (
  input  logic [TC_W-1:0]  tileCol,
  input  logic [TC_W-1:0]  tileRow,
  input  logic [TPR_W-1:0] tilesPerRow,
  output logic [IDX_W-1:0] tileIdx
);

  localparam int CW = ((TC_W > TPR_W) ? TC_W : TPR_W) + 1;

  logic          oddRow;
  logic [CW-1:0] colExt;
  logic [CW-1:0] tprExt;
  logic [CW-1:0] effCol;

  assign oddRow = tileRow[0];
  assign colExt = CW'(tileCol);
  assign tprExt = CW'(tilesPerRow);

  // Serpentine: odd rows count columns from the right end
  assign effCol  = oddRow ? (tprExt - CW'(1) - colExt) : colExt;
  assign tileIdx = IDX_W'(tileRow) * IDX_W'(tilesPerRow) + IDX_W'(effCol);

  // R9: a legal column mirrors to a legal column
  always_comb begin
    if (oddRow && (colExt < tprExt)) begin
      a_r9_mirror_range: assert (effCol < tprExt);
    end
  end

endmodule

// File: rtl/tt_datapath.sv
module tt_datapath
  import tt_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int TPR_W   = 8,
  parameter int OFF_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  tt_strobe_t         strobe,
  input  logic [COORD_W-1:0] inX,
  input  logic [COORD_W-1:0] inY,
  input  logic [TPR_W-1:0]   tilesPerRow,
  input  logic [OFF_W-1:0]   baseAddr,
  output logic [OFF_W-1:0]   outOffset
);

  localparam int TC_W  = COORD_W - TILE_SHIFT;
  localparam int IDX_W = TC_W + TPR_W + 1;
  localparam int RAW_W = IDX_W + TILE_LSB;

  logic [TC_W-1:0]  tileCol;
  logic [TC_W-1:0]  tileRow;
  logic [IDX_W-1:0] tileIdx;
  logic [1:0]       slot;
  logic [RAW_W-1:0] rawOff;
  logic [OFF_W-1:0] nextOff;
  logic [OFF_W-1:0] offQ;

  assign tileCol = inX[COORD_W-1:TILE_SHIFT];
  assign tileRow = inY[COORD_W-1:TILE_SHIFT];

  tt_tile_index #(
    .TC_W  (TC_W),
    .TPR_W (TPR_W),
    .IDX_W (IDX_W)
  ) uIdx (
    .tileCol     (tileCol),
    .tileRow     (tileRow),
    .tilesPerRow (tilesPerRow),
    .tileIdx     (tileIdx)
  );

  tt_slot_map uSlot (
    .oddRow (tileRow[0]),
    .subCol (inX[4]),
    .subRow (inY[4]),
    .slot   (slot)
  );

  // Every level is a power of two, so the offset is a field concatenation
  assign rawOff  = {tileIdx, slot, inY[3:2], inX[3:2], inY[1:0], inX[1:0], 2'b00};
  assign nextOff = baseAddr + OFF_W'(rawOff);

  always_ff @(posedge clk) begin
    if (rst) begin
      offQ <= '0;
    end else if (strobe.load) begin
      offQ <= nextOff;
    end
  end

  assign outOffset = offQ;

endmodule

// File: rtl/tt_addr_gen.sv
module tt_addr_gen
  import tt_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int TPR_W   = 8,
  parameter int OFF_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inReady,
  input  logic [COORD_W-1:0] inX,
  input  logic [COORD_W-1:0] inY,
  input  logic [TPR_W-1:0]   tilesPerRow,
  input  logic [OFF_W-1:0]   baseAddr,
  output logic               outValid,
  input  logic               outReady,
  output logic [OFF_W-1:0]   outOffset
);

  tt_strobe_t strobe;

  tt_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  tt_datapath #(
    .COORD_W (COORD_W),
    .TPR_W   (TPR_W),
    .OFF_W   (OFF_W)
  ) uData (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .inX         (inX),
    .inY         (inY),
    .tilesPerRow (tilesPerRow),
    .baseAddr    (baseAddr),
    .outOffset   (outOffset)
  );

  // R3: a stalled result is held unchanged
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outOffset)));

endmodule

// File: tb/tb_tt_addr_gen.sv
module tb_tt_addr_gen;

  localparam int COORD_W = 12;
  localparam int TPR_W   = 8;
  localparam int OFF_W   = 32;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               inValid = 1'b0;
  logic               inReady;
  logic [COORD_W-1:0] inX = '0;
  logic [COORD_W-1:0] inY = '0;
  logic [TPR_W-1:0]   tilesPerRow = 8'd4;
  logic [OFF_W-1:0]   baseAddr = '0;
  logic               outValid;
  logic               outReady = 1'b1;
  logic [OFF_W-1:0]   outOffset;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  tt_addr_gen #(.COORD_W(COORD_W), .TPR_W(TPR_W), .OFF_W(OFF_W)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inX(inX), .inY(inY), .tilesPerRow(tilesPerRow), .baseAddr(baseAddr),
    .outValid(outValid), .outReady(outReady), .outOffset(outOffset)
  );

  // {x[12], y[12], expected offset[24]} with tilesPerRow = 4, base 0
  localparam logic [47:0] VEC [0:15] = '{
    {12'd0,   12'd0,  24'd0},      // R4 origin
    {12'd1,   12'd0,  24'd4},      // R4 pixel column
    {12'd0,   12'd1,  24'd16},     // R4 pixel row
    {12'd4,   12'd0,  24'd64},     // R5 micro column
    {12'd0,   12'd4,  24'd256},    // R5 micro row
    {12'd15,  12'd15, 24'd1020},   // R5 last word of sub-tile
    {12'd0,   12'd16, 24'd1024},   // R6 top-left slot 1
    {12'd16,  12'd16, 24'd2048},   // R6 top-right slot 2
    {12'd16,  12'd0,  24'd3072},   // R6 bottom-right slot 3
    {12'd32,  12'd0,  24'd4096},   // R8 next tile
    {12'd0,   12'd32, 24'd30720},  // R7 R9 BL slot 2, mirrored col 3
    {12'd96,  12'd32, 24'd18432},  // R9 last column mirrors to 0
    {12'd112, 12'd48, 24'd16384},  // R7 top-right slot 0
    {12'd16,  12'd32, 24'd29696},  // R7 bottom-right slot 1
    {12'd0,   12'd48, 24'd31744},  // R7 top-left slot 3
    {12'd5,   12'd70, 24'd33124}   // R8 even row 2, mixed bits
  };

  function automatic logic [31:0] refOff(int x, int y, int tpr, logic [31:0] base);
    int evenTab[4];
    int oddTab[4];
    int tc, tr, col, pos, sl;
    evenTab = '{0, 3, 1, 2};  // index {subRow,subCol}: BL, BR, TL, TR
    oddTab  = '{2, 1, 3, 0};
    tc  = x / 32;
    tr  = y / 32;
    col = (tr % 2 == 1) ? (tpr - 1 - tc) : tc;
    pos = ((y / 16) % 2) * 2 + ((x / 16) % 2);
    sl  = (tr % 2 == 1) ? oddTab[pos] : evenTab[pos];
    return base + 32'((tr * tpr + col) * 4096 + sl * 1024
         + (((y / 4) % 4) * 4 + (x / 4) % 4) * 64 + ((y % 4) * 4 + x % 4) * 4);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(int x, int y, int tpr, logic [31:0] base,
                       output logic [31:0] got, output logic gotValid);
    @(negedge clk);
    inX = COORD_W'(x); inY = COORD_W'(y);
    tilesPerRow = TPR_W'(tpr); baseAddr = base;
    inValid = 1'b1; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    got = outOffset; gotValid = outValid;
  endtask

  task automatic tileSweep(int tc, int tr, int tpr, string tag);
    bit seen [0:1023];
    logic [31:0] got;
    logic gv;
    logic [31:0] tileBase;
    logic [31:0] rel;
    int bad = 0;
    int col;
    col = (tr % 2 == 1) ? (tpr - 1 - tc) : tc;
    tileBase = 32'((tr * tpr + col) * 4096);
    for (int i = 0; i < 1024; i++) seen[i] = 1'b0;
    for (int p = 0; p < 1024; p++) begin
      issue(tc * 32 + p % 32, tr * 32 + p / 32, tpr, 32'd0, got, gv);
      rel = got - tileBase;
      if (!gv || rel >= 32'd4096 || rel[1:0] != 2'b00 || seen[rel[11:2]]) bad++;
      else seen[rel[11:2]] = 1'b1;
    end
    check(tag, 64'(bad), 64'd0);  // R11
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] got;
    logic gv;

    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'(outValid), 64'd0);
    check("R2 ready empty", 64'(inReady), 64'd1);
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < 16; i++) begin
      issue(int'(VEC[i][47:36]), int'(VEC[i][35:24]), 4, 32'd0, got, gv);
      check($sformatf("R3 valid vec%0d", i), 64'(gv), 64'd1);
      check($sformatf("R4-8 vec%0d (R4 R5 R6 R7 R8 R9)", i), 64'(got), 64'(VEC[i][23:0]));
    end

    // R9 degenerate width of one tile
    issue(0, 32, 1, 32'd0, got, gv);
    check("R9 tpr1", 64'(got), 64'd6144);
    // R9 far corner, 128 tiles per row
    issue(4095, 4095, 128, 32'd0, got, gv);
    check("R9 corner", 64'(got), 64'd66585596);
    // R10 base addition
    issue(0, 0, 4, 32'h1000_0000, got, gv);
    check("R10 base", 64'(got), 64'h1000_0000);
    issue(16, 16, 4, 32'h100, got, gv);
    check("R10 base off", 64'(got), 64'd2304);
    issue(0, 0, 4, 32'hFFFF_FFFC, got, gv);
    check("R10 wrap", 64'(got), 64'hFFFF_FFFC);
    issue(4, 0, 4, 32'hFFFF_FFFC, got, gv);
    check("R10 wrap", 64'(got), 64'd60);

    // Reference sweep, odd width of five tiles
    for (int i = 0; i < 300; i++) begin
      int x = (i * 37 + 11) % 160;
      int y = (i * 53 + 7) % 4096;
      issue(x, y, 5, 32'h40, got, gv);
      check($sformatf("R8 R9 sweep x%0d y%0d", x, y), 64'(got), 64'(refOff(x, y, 5, 32'h40)));
    end

    // Backpressure: R2, R3
    @(negedge clk);
    outReady = 1'b0;
    inX = 12'd16; inY = 12'd0; tilesPerRow = 8'd4; baseAddr = '0; inValid = 1'b1;
    @(negedge clk);
    check("R3 stall valid", 64'(outValid), 64'd1);
    check("R2 stall ready", 64'(inReady), 64'd0);
    inX = 12'd0; inY = 12'd16;  // second request waits
    @(negedge clk);
    check("R3 stall hold", 64'(outOffset), 64'd3072);
    check("R3 stall valid2", 64'(outValid), 64'd1);
    outReady = 1'b1;
    #1;
    check("R2 drain ready", 64'(inReady), 64'd1);
    @(negedge clk);
    inValid = 1'b0;
    check("R2 same-cycle accept", 64'(outOffset), 64'd1024);
    check("R3 valid after swap", 64'(outValid), 64'd1);
    @(negedge clk);
    check("R3 drained", 64'(outValid), 64'd0);

    // R1 reset while a result is stalled
    outReady = 1'b0;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset stalled", 64'(outValid), 64'd0);
    check("R2 ready after reset", 64'(inReady), 64'd1);
    rst = 1'b0;
    outReady = 1'b1;

    // R11 distinctness in an even and an odd tile row
    tileSweep(1, 0, 5, "R11 even tile");
    tileSweep(2, 1, 5, "R11 odd tile");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule